// File: doc/BRIEF.md
# External Interrupt Pin Qualifier with Wake-Up

This block watches a group of external interrupt request pins. Each pin is brought into the main clock domain through a short flop chain. Its level then has to stay unchanged for a minimum number of clock samples before the block accepts it. Each pin has one of four trigger conditions: rising edge, falling edge, high level or low level. An accepted event sets a per-pin detect flag. If the pin is enabled, it also sets a request flag, and the enabled request flags are combined into one interrupt output.

A two-bit power-mode input changes how the pins are judged. In RUN and SLEEP the hold threshold is the short one. In HALT a longer hold is needed. STOP uses the short hold again. In HALT and STOP only level triggers count; edge-configured pins are ignored. When the mode is not RUN, any accepted event on an enabled pin drives a wake-up output. Software uses one write port to configure pins and to clear flags. That port has no handshake, and a write takes effect on the clock edge where it is presented. The block has no streaming data path.

Top module: `extirq_wake_detect`

## Requirements
- R1: After reset, all detect and request flags, `irq_o` and `wake_o` are low. Every pin is configured for falling-edge trigger with its enable off.
- R2: A level-triggered pin is detected once its active level has been sampled on HOLD_RUN (10) consecutive clock edges in RUN, SLEEP or STOP mode. Nine samples produce nothing. The flag rises two clock edges after the last qualifying sample.
- R3: An edge is accepted only when two conditions both hold. The level before the transition must have lasted at least the threshold number of samples, and the new level must last HOLD_RUN samples. Each qualified transition gives exactly one detection.
- R4: In HALT mode the hold threshold is HOLD_HALT (22) samples for both detection and wake-up. A 21-sample level produces nothing.
- R5: In HALT and STOP modes, pins set for an edge trigger produce neither a flag nor a wake-up, however long the new level lasts.
- R6: In SLEEP, HALT or STOP, a detection on an enabled pin raises `wake_o` on the same edge that sets the flag. SLEEP accepts all four trigger types. A detection on a disabled pin never raises `wake_o`.
- R7: `wake_o` is never high when the power mode on the previous edge was RUN (`pwr_mode_i` 0=RUN, 1=SLEEP, 2=HALT, 3=STOP).
- R8: Every detection sets the pin's detect flag. The request flag is set only if the pin is enabled. `irq_o` is the OR over all pins of request flag AND enable, so disabling a pin masks its pending request.
- R9: A write with address bit 3 clear configures the pin given by address bits 2:0. Data bits 1:0 select the trigger (0 falling edge, 1 rising edge, 2 low level, 3 high level) and data bit 2 is the enable.
- R10: A write with address bit 3 set clears both flags of every pin whose bit is set in the data mask, and leaves the other pins untouched. The clear wins over a detection on the same edge. A level that is still held sets the flags again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | External interrupt request pins, asynchronous |
| pwr_mode_i | input | 2 | Power mode: 0 RUN, 1 SLEEP, 2 HALT, 3 STOP |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | $clog2(NPINS)+1 | Write address: top bit selects clear, low bits select the pin |
| wr_data_i | input | max(NPINS,3) | Write data: pin configuration or clear mask |
| det_o | output | NPINS | Per-pin detect flags |
| req_o | output | NPINS | Per-pin request flags |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The hardest situation to reach is a flag clear that lands on the same edge as a fresh detection. Here the clear must win, and the flag must come back exactly one edge later. The bench holds two level-triggered pins at their active level until detection repeats every cycle. It then issues a clear for one pin only and samples both flags on the two following cycles. A second hard case is the pre-edge stability rule. The bench qualifies one rising edge, then drops the pin for only five cycles before raising it again, and expects the second rise to be ignored.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  typedef enum logic [1:0] {
    TRIG_FALL = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_HIGH = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_HALT  = 2'd2,
    PM_STOP  = 2'd3
  } pmode_e;

  typedef struct packed {
    trig_e trig;
    logic  en;
  } pin_cfg_t;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_pin_qual.sv
module extirq_pin_qual
  import extirq_pkg::*;
#(
  parameter int HOLD_RUN  = 10,
  parameter int HOLD_HALT = 22,
  localparam int RUN_MAX  = HOLD_HALT + 1,
  localparam int CNT_W    = $clog2(RUN_MAX + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl_i,
  input  trig_e  trig_i,
  input  pmode_e mode_i,
  output logic   accept_o
);
  logic             prev_q;
  logic             pre_ok_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_n;
  logic [CNT_W-1:0] thr;
  logic             changed;
  logic             deep;
  logic             level_hit;
  logic             edge_hit;

  assign thr     = (mode_i == PM_HALT) ? CNT_W'(HOLD_HALT) : CNT_W'(HOLD_RUN);
  assign deep    = (mode_i == PM_HALT) || (mode_i == PM_STOP);
  assign changed = (lvl_i != prev_q);

  always_comb begin
    if (changed)                       run_n = CNT_W'(1);
    else if (run_q >= CNT_W'(RUN_MAX)) run_n = CNT_W'(RUN_MAX);
    else                               run_n = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      run_q    <= '0;
      pre_ok_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      run_q  <= run_n;
      if (changed) pre_ok_q <= (run_q >= thr);
    end
  end

  assign level_hit = (run_n >= thr);
  assign edge_hit  = (run_n == thr) && pre_ok_q;

  always_comb begin
    unique case (trig_i)
      TRIG_HIGH: accept_o = lvl_i && level_hit;
      TRIG_LOW:  accept_o = !lvl_i && level_hit;
      TRIG_RISE: accept_o = !deep && lvl_i && edge_hit;
      TRIG_FALL: accept_o = !deep && !lvl_i && edge_hit;
      default:   accept_o = 1'b0;
    endcase
  end

  // R2: an accepted event always comes from a level that was already steady
  assert_accept_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (lvl_i == $past(lvl_i)));

  // R3: an edge trigger yields a single-cycle acceptance per transition
  assert_edge_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !trig_i[1]) |=> !(accept_o && !trig_i[1]));
endmodule

// File: rtl/extirq_flag_bank.sv
module extirq_flag_bank #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] accept_i,
  input  logic [NPINS-1:0] en_i,
  input  logic             clr_i,
  input  logic [NPINS-1:0] clr_mask_i,
  output logic [NPINS-1:0] det_o,
  output logic [NPINS-1:0] req_o,
  output logic             irq_o
);
  logic [NPINS-1:0] det_q;
  logic [NPINS-1:0] req_q;

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          det_q[i] <= 1'b0;
          req_q[i] <= 1'b0;
        end else if (clr_i && clr_mask_i[i]) begin
          det_q[i] <= 1'b0;
          req_q[i] <= 1'b0;
        end else begin
          if (accept_i[i])           det_q[i] <= 1'b1;
          if (accept_i[i] && en_i[i]) req_q[i] <= 1'b1;
        end
      end
    end
  endgenerate

  assign det_o = det_q;
  assign req_o = req_q;
  assign irq_o = |(req_q & en_i);

  // R10: a clear always leaves the masked flags low on the following cycle
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((det_o & $past(clr_mask_i)) == '0));
endmodule

// File: rtl/extirq_wake_detect.sv
module extirq_wake_detect
  import extirq_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_RUN    = 10,
  parameter int HOLD_HALT   = 22,
  localparam int IW         = $clog2(NPINS),
  localparam int AW         = IW + 1,
  localparam int DW         = (NPINS > 3) ? NPINS : 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [1:0]       pwr_mode_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [NPINS-1:0] det_o,
  output logic [NPINS-1:0] req_o,
  output logic             irq_o,
  output logic             wake_o
);
  pmode_e           mode;
  logic             clr_hit;
  logic [NPINS-1:0] accept_v;
  logic [NPINS-1:0] en_v;
  logic             wake_q;

  assign mode    = pmode_e'(pwr_mode_i);
  assign clr_hit = wr_en_i && wr_addr_i[AW-1];

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pin_cfg_t cfg_q;
      logic     cfg_hit;
      logic     lvl_s;

      assign cfg_hit = wr_en_i && !wr_addr_i[AW-1] && (wr_addr_i[IW-1:0] == IW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg_q <= '{trig: TRIG_FALL, en: 1'b0};
        else if (cfg_hit) cfg_q <= '{trig: trig_e'(wr_data_i[1:0]), en: wr_data_i[2]};
      end

      extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i[i]),
        .q_o   (lvl_s)
      );

      extirq_pin_qual #(.HOLD_RUN(HOLD_RUN), .HOLD_HALT(HOLD_HALT)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl_s),
        .trig_i   (cfg_q.trig),
        .mode_i   (mode),
        .accept_o (accept_v[i])
      );

      assign en_v[i] = cfg_q.en;
    end
  endgenerate

  extirq_flag_bank #(.NPINS(NPINS)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept_v),
    .en_i       (en_v),
    .clr_i      (clr_hit),
    .clr_mask_i (wr_data_i[NPINS-1:0]),
    .det_o      (det_o),
    .req_o      (req_o),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= (mode != PM_RUN) && |(accept_v & en_v);
  end

  assign wake_o = wake_q;

  // R7: wake-up never follows a cycle spent in RUN
  assert_no_wake_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(pwr_mode_i) != 2'd0));
endmodule

// File: tb/extirq_wake_detect_tb_top.sv
`timescale 1ns/1ps
module extirq_wake_detect_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = '0;
  logic [1:0] pmode = 2'd0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] det, req;
  logic       irq, wake;
  logic       wake_seen;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  extirq_wake_detect dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .pwr_mode_i(pmode),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .det_o(det), .req_o(req), .irq_o(irq), .wake_o(wake)
  );

  always @(negedge clk) begin
    if (!rst_n)    wake_seen <= 1'b0;
    else if (wake) wake_seen <= 1'b1;
  end

  typedef struct packed {
    logic [1:0] pm;
    logic [1:0] tr;
    logic       en;
    logic       pre;
    logic [7:0] hold;
    logic       edet;
    logic       ereq;
    logic       ewake;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 2'd3, 1'b1, 1'b0, 8'd10, 1'b1, 1'b1, 1'b0}, // R2 high level, exact hold
    '{2'd0, 2'd3, 1'b1, 1'b0, 8'd9,  1'b0, 1'b0, 1'b0}, // R2 one short
    '{2'd0, 2'd2, 1'b0, 1'b1, 8'd10, 1'b1, 1'b0, 1'b0}, // R8 low level, disabled
    '{2'd0, 2'd1, 1'b1, 1'b0, 8'd10, 1'b1, 1'b1, 1'b0}, // R3 rising edge
    '{2'd0, 2'd1, 1'b1, 1'b0, 8'd9,  1'b0, 1'b0, 1'b0}, // R3 rising too short
    '{2'd0, 2'd0, 1'b1, 1'b1, 8'd12, 1'b1, 1'b1, 1'b0}, // R3 falling edge
    '{2'd1, 2'd1, 1'b1, 1'b0, 8'd10, 1'b1, 1'b1, 1'b1}, // R6 sleep edge wake
    '{2'd1, 2'd2, 1'b1, 1'b1, 8'd10, 1'b1, 1'b1, 1'b1}, // R6 sleep level wake
    '{2'd2, 2'd3, 1'b1, 1'b0, 8'd22, 1'b1, 1'b1, 1'b1}, // R4 halt long hold
    '{2'd2, 2'd3, 1'b1, 1'b0, 8'd21, 1'b0, 1'b0, 1'b0}, // R4 halt one short
    '{2'd2, 2'd1, 1'b1, 1'b0, 8'd40, 1'b0, 1'b0, 1'b0}, // R5 halt edge ignored
    '{2'd3, 2'd2, 1'b1, 1'b1, 8'd10, 1'b1, 1'b1, 1'b1}, // R6 stop level wake
    '{2'd3, 2'd0, 1'b1, 1'b1, 8'd40, 1'b0, 1'b0, 1'b0}, // R5 stop edge ignored
    '{2'd3, 2'd3, 1'b1, 1'b0, 8'd9,  1'b0, 1'b0, 1'b0}, // R2 stop short hold
    '{2'd1, 2'd3, 1'b0, 1'b0, 8'd10, 1'b1, 1'b0, 1'b0}  // R6 disabled pin no wake
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] pv, input logic [1:0] pm);
    @(negedge clk);
    rst_n = 1'b0;
    pin   = pv;
    pmode = pm;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    // R1 reset state
    do_reset(8'h00, 2'd0);
    cyc(1);
    chk("R1 det", int'(det), 0);
    chk("R1 req", int'(req), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 wake", int'(wake), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_reset({7'b0, VECS[v].pre}, VECS[v].pm);
      wr(4'd0, {5'b0, VECS[v].en, VECS[v].tr});      // R9 config encoding
      cyc(30);
      pin[0] = ~VECS[v].pre;
      cyc(int'(VECS[v].hold));
      pin[0] = VECS[v].pre;
      cyc(30);
      chk($sformatf("R9 vec%0d det", v), int'(det[0]), int'(VECS[v].edet));
      chk($sformatf("R8 vec%0d req", v), int'(req[0]), int'(VECS[v].ereq));
      chk($sformatf("R8 vec%0d irq", v), int'(irq), int'(VECS[v].ereq));
      chk($sformatf("R6 R7 vec%0d wake", v), int'(wake_seen), int'(VECS[v].ewake));
    end

    // R1 default trigger is falling edge, default enable off
    do_reset(8'h01, 2'd0);
    cyc(30);
    pin[0] = 1'b0;
    cyc(30);
    chk("R1 default falling det", int'(det[0]), 1);
    chk("R1 default disabled req", int'(req[0]), 0);

    // R3 pre-edge level must be stable
    do_reset(8'h00, 2'd0);
    wr(4'd0, 8'h05);
    cyc(30);
    pin[0] = 1'b1;
    cyc(30);
    chk("R3 qualified rise", int'(det[0]), 1);
    wr(4'd8, 8'h01);
    pin[0] = 1'b0;
    cyc(5);
    pin[0] = 1'b1;
    cyc(30);
    chk("R3 unstable pre-edge ignored", int'(det[0]), 0);

    // R10 clear beats detection, masked only, level re-flags
    do_reset(8'h00, 2'd0);
    wr(4'd0, 8'h07);
    wr(4'd1, 8'h07);
    pin[1:0] = 2'b11;
    cyc(20);
    chk("R10 both set", int'(det[1:0]), 3);
    wr(4'd8, 8'h01);
    chk("R10 clear wins", int'(det[0]), 0);
    chk("R10 clear req", int'(req[0]), 0);
    chk("R10 unmasked kept", int'(det[1]), 1);
    cyc(1);
    chk("R10 level re-flag", int'(det[0]), 1);

    // R8 disabling masks irq but keeps request
    do_reset(8'h00, 2'd0);
    wr(4'd0, 8'h07);
    pin[0] = 1'b1;
    cyc(20);
    chk("R8 irq on", int'(irq), 1);
    wr(4'd0, 8'h03);
    chk("R8 irq masked", int'(irq), 0);
    chk("R8 req kept", int'(req[0]), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule